// File: doc/BRIEF.md
# Bus Transfer Lifecycle Monitor

A passive observer for one peripheral register bus link between a manager and a subordinate. It watches the select, enable and ready handshake, together with direction, address, write data and read data. From these signals alone it rebuilds the phase of every transfer. A bus cycle is idle when select is low, setup when select is high and enable is low, and access when both are high. Any step off the legal path is reported. The path is idle, then exactly one setup cycle, then one or more access cycles, then idle or a new setup.

Each sampled clock edge gives at most one registered result. The result is one of: a violation pulse with a 3-bit cause code, a completion pulse with the number of wait cycles that transfer spent, or a flag showing that a new setup followed a completion directly. Read data seen on the completing edge of a read is latched and presented. The monitor drives nothing onto the bus and is meant to sit beside a manager or a subordinate in simulation or on silicon.

Top module: `apb_lifecycle_monitor`

## Requirements
- R1: While rst_n is low (asynchronous, active low), every output is zero and the tracked phase returns to idle, so the first transfer after reset starts clean.
- R2: A setup cycle whose next cycle is not an access cycle (idle, or a second setup) raises viol_o for one cycle with viol_code_o = 3'd1.
- R3: An access cycle (or bus_enable high) that follows an idle cycle rather than a setup or waiting access cycle raises viol_code_o = 3'd2 and does not produce a completion.
- R4: done_o pulses for exactly one cycle, one clock after an edge that samples select, enable and ready all high, provided the access was entered from setup or a waiting access cycle. A two-cycle transfer (setup plus one access) completes with wait_cnt_o = 0.
- R5: Each access cycle sampled with ready low adds one to the wait count. The count appears on wait_cnt_o only while done_o is high (zero otherwise) and restarts from zero for the next transfer.
- R6: The wait count saturates at 2^WAIT_W-1 (255 by default) and does not wrap.
- R7: If bus_addr or bus_write in any access cycle differs from the value sampled in that transfer's setup cycle, viol_code_o = 3'd3.
- R8: In a write transfer, bus_wdata in an access cycle differing from the setup value gives viol_code_o = 3'd4. In a read transfer, changes of bus_wdata are ignored and raise no violation.
- R9: bus_enable still high on the cycle after a completion gives viol_code_o = 3'd5.
- R10: An access cycle with ready low that is followed by any cycle which is not access (select dropped or enable dropped) is an aborted transfer and gives viol_code_o = 3'd6.
- R11: b2b_o pulses for one cycle, one clock after a setup cycle that immediately follows a completing access cycle. It stays low when an idle cycle separates the two transfers.
- R12: On completion of a read, rdata_o takes the bus_rdata value sampled on the completing edge and holds it until the next completed read. A completed write leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Observed subordinate select |
| bus_enable | input | 1 | Observed access-phase enable |
| bus_ready | input | 1 | Observed subordinate ready |
| bus_write | input | 1 | Observed direction, 1 = write |
| bus_addr | input | ADDR_W | Observed address |
| bus_wdata | input | DATA_W | Observed write data |
| bus_rdata | input | DATA_W | Observed read data |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Violation cause, 0 when no violation |
| done_o | output | 1 | One-cycle completion pulse |
| wait_cnt_o | output | WAIT_W | Wait cycles of the completed transfer |
| b2b_o | output | 1 | Back-to-back setup pulse |
| rdata_o | output | DATA_W | Read data latched at read completion |

## Verification
Every result is registered once. A violation, completion, wait count, back-to-back flag or latched read value that belongs to a bus cycle is visible during the cycle that follows the clock edge sampling it. It is never visible in the same cycle, and never two cycles later. The bench drives one bus cycle per step, waits for the sampling edge, and reads the outputs a nanosecond after that edge, before it presents the next cycle. The cycle after each violation is also checked, to show that the pulse has dropped.

// File: rtl/apb_lifecycle_monitor.sv
module apb_lifecycle_monitor #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              viol_o,
  output logic [2:0]        viol_code_o,
  output logic              done_o,
  output logic [WAIT_W-1:0] wait_cnt_o,
  output logic              b2b_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [WAIT_W-1:0] WAIT_MAX = {WAIT_W{1'b1}};

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_WAIT, PH_DONE} phase_t;

  phase_t            ph;
  logic [WAIT_W-1:0] cnt;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic              cap_write;
  logic [2:0]        err;

  wire is_setup  = bus_sel & ~bus_enable;
  wire is_access = bus_sel & bus_enable;
  wire legal_in  = (ph == PH_SETUP) || (ph == PH_WAIT);
  wire completes = is_access & bus_ready & legal_in;
  wire ctl_moved = (bus_addr != cap_addr) || (bus_write != cap_write);
  wire wd_moved  = cap_write && (bus_wdata != cap_wdata);

  always_comb begin
    err = 3'd0;
    if (ph == PH_SETUP && !is_access)                 err = 3'd1;
    else if (ph == PH_WAIT && !is_access)             err = 3'd6;
    else if (bus_enable && ph == PH_DONE)             err = 3'd5;
    else if (bus_enable && ph == PH_IDLE)             err = 3'd2;
    else if (is_access && legal_in && ctl_moved)      err = 3'd3;
    else if (is_access && legal_in && wd_moved)       err = 3'd4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      cnt         <= '0;
      cap_addr    <= '0;
      cap_wdata   <= '0;
      cap_write   <= 1'b0;
      viol_o      <= 1'b0;
      viol_code_o <= 3'd0;
      done_o      <= 1'b0;
      wait_cnt_o  <= '0;
      b2b_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      if (is_setup)       ph <= PH_SETUP;
      else if (is_access) ph <= bus_ready ? PH_DONE : PH_WAIT;
      else                ph <= PH_IDLE;

      if (is_access && !bus_ready) cnt <= (cnt == WAIT_MAX) ? cnt : cnt + 1'b1;
      else                         cnt <= '0;

      if (is_setup) begin
        cap_addr  <= bus_addr;
        cap_wdata <= bus_wdata;
        cap_write <= bus_write;
      end

      viol_o      <= (err != 3'd0);
      viol_code_o <= err;
      done_o      <= completes;
      wait_cnt_o  <= completes ? cnt : '0;
      b2b_o       <= is_setup && (ph == PH_DONE);
      if (completes && !cap_write) rdata_o <= bus_rdata;
    end
  end

  assert_code_matches_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o == (viol_code_o != 3'd0));

  assert_single_completion_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_b2b_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    b2b_o |-> $past(done_o));

  assert_wait_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> wait_cnt_o == '0);

  assert_setup_then_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_enable) ##1 !(bus_sel && bus_enable) |=> viol_o && viol_code_o == 3'd1);

  assert_rdata_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rdata_o));

endmodule

// File: tb/apb_lifecycle_monitor_tb_top.sv
`timescale 1ns/1ps
module apb_lifecycle_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, en = 1'b0, rdy = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wd = '0, rd = '0;
  logic        viol, done, b2b;
  logic [2:0]  code;
  logic [7:0]  wcnt;
  logic [31:0] rdo;
  int          n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  apb_lifecycle_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_enable(en), .bus_ready(rdy),
    .bus_write(wr), .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rd),
    .viol_o(viol), .viol_code_o(code), .done_o(done), .wait_cnt_o(wcnt),
    .b2b_o(b2b), .rdata_o(rdo));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic e, input logic r);
    sel = s; en = e; rdy = r;
    @(posedge clk); #1;
  endtask

  task automatic idle(); cyc(0, 0, 0); endtask

  task automatic expect_ok(input string req);
    chk(req, "viol", viol, 0);
    chk(req, "code", code, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "viol", viol, 0); chk("R1", "done", done, 0);
    chk("R1", "wait", wcnt, 0); chk("R1", "b2b", b2b, 0); chk("R1", "rdata", rdo, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(); expect_ok("R1");
  endtask

  task automatic t_basic_write();
    wr = 1; addr = 16'h0010; wd = 32'h1111;
    cyc(1, 0, 0); chk("R4", "done at setup", done, 0);
    cyc(1, 1, 1); chk("R4", "done", done, 1); chk("R4", "wait", wcnt, 0); expect_ok("R4");
    chk("R12", "rdata unchanged by write", rdo, 0);
    idle(); chk("R4", "done one cycle", done, 0); expect_ok("R4");
  endtask

  task automatic t_wait_read();
    wr = 0; addr = 16'h0020; rd = 32'hA5A5_0001;
    cyc(1, 0, 0);
    for (int i = 0; i < 3; i++) begin cyc(1, 1, 0); chk("R5", "no done while waiting", done, 0); end
    cyc(1, 1, 1); chk("R5", "wait count", wcnt, 3); chk("R4", "done", done, 1);
    chk("R12", "rdata", rdo, 32'hA5A5_0001); expect_ok("R5");
    rd = 32'h0;
    idle(); chk("R5", "wait cleared", wcnt, 0); chk("R12", "rdata held", rdo, 32'hA5A5_0001);
    cyc(1, 0, 0); cyc(1, 1, 1); chk("R5", "fresh count", wcnt, 0);
    idle();
  endtask

  task automatic t_b2b();
    wr = 0; addr = 16'h0030;
    cyc(1, 0, 0); cyc(1, 1, 1);
    cyc(1, 0, 0); chk("R11", "b2b", b2b, 1); expect_ok("R11");
    cyc(1, 1, 1); chk("R11", "b2b drops", b2b, 0); chk("R11", "second done", done, 1);
    idle(); cyc(1, 0, 0); chk("R11", "no b2b after idle", b2b, 0);
    cyc(1, 1, 1); idle();
  endtask

  task automatic t_double_setup();
    cyc(1, 0, 0); cyc(1, 0, 0);
    chk("R2", "viol", viol, 1); chk("R2", "code", code, 1);
    cyc(1, 1, 1); chk("R2", "pulse drops", viol, 0);
    idle(); cyc(1, 0, 0); idle();
    chk("R2", "setup then idle", code, 1);
    idle(); expect_ok("R2");
  endtask

  task automatic t_skip_setup();
    cyc(1, 1, 1); chk("R3", "code", code, 2); chk("R3", "no done", done, 0);
    idle(); expect_ok("R3");
  endtask

  task automatic t_addr_change();
    wr = 0; addr = 16'h0040;
    cyc(1, 0, 0); cyc(1, 1, 0); expect_ok("R7");
    addr = 16'h0044; cyc(1, 1, 0); chk("R7", "addr code", code, 3);
    addr = 16'h0040; cyc(1, 1, 1); expect_ok("R7"); chk("R7", "done", done, 1); chk("R5", "wait", wcnt, 2);
    idle();
    cyc(1, 0, 0); wr = 1; cyc(1, 1, 1); chk("R7", "dir code", code, 3);
    wr = 0; idle();
  endtask

  task automatic t_wdata();
    wr = 1; addr = 16'h0050; wd = 32'h1;
    cyc(1, 0, 0); wd = 32'h2; cyc(1, 1, 0); chk("R8", "write data code", code, 4);
    cyc(1, 1, 1); idle();
    wr = 0; wd = 32'h1;
    cyc(1, 0, 0); wd = 32'h7; cyc(1, 1, 0); expect_ok("R8");
    cyc(1, 1, 1); expect_ok("R8"); chk("R8", "read done", done, 1);
    idle();
  endtask

  task automatic t_hold_enable();
    cyc(1, 0, 0); cyc(1, 1, 1);
    cyc(1, 1, 1); chk("R9", "code", code, 5); chk("R9", "no done", done, 0);
    idle(); expect_ok("R9");
  endtask

  task automatic t_abort();
    cyc(1, 0, 0); cyc(1, 1, 0);
    idle(); chk("R10", "code", code, 6); chk("R10", "no done", done, 0);
    cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 0, 0); chk("R10", "enable drop code", code, 6);
    cyc(1, 1, 1); idle();
  endtask

  task automatic t_saturate();
    cyc(1, 0, 0);
    for (int i = 0; i < 300; i++) cyc(1, 1, 0);
    cyc(1, 1, 1); chk("R6", "saturated", wcnt, 255); chk("R6", "done", done, 1);
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset(); t_basic_write(); t_wait_read(); t_b2b(); t_double_setup();
        t_skip_setup(); t_addr_change(); t_wdata(); t_hold_enable(); t_abort(); t_saturate();
      end
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule